// File: doc/BRIEF.md
# Switch Debouncer with History Pattern Match

This block cleans up one mechanical push-button input and turns it into single-cycle press and release events. The button drives an active-low raw line, which is brought into the clock domain through a short chain of flip-flops. A periodic strobe, typically a few milliseconds apart and generated elsewhere, then loads the synchronized level into a shift register that holds the most recent samples. No counter measures how long the line has been steady. The block compares the whole sample history against one exact word, and that single comparison does both the debouncing and the edge detection.

A press is reported only when a long run of released samples is followed by a short run of pressed samples. That exact word exists for just one strobe interval, so the event fires once, when the line first becomes stable. A bounce that returns to released, or a press that follows too soon after a previous one, leaves the history off-pattern and produces no event. A release is found in the same way by the complementary word, and a parameter can turn it off. The latency from strobe to event is fixed.

Top module: `hist_match_debounce`

## Requirements
- R1: While reset is high and on the cycle after it falls, `press_o` and `release_o` are 0, and reset loads the history as if every past sample had been released.
- R2: The input is sampled only on clocks where `tick_i` is high. A change on `key_n_i` that starts and ends between two strobes, clear of the synchronizer window, produces no event.
- R3: Samples enter the history at bit 0 and older ones move toward the top. A sample of 1 means released (`key_n_i` high). `press_o` fires when the 16-bit history equals 0xFFF0: twelve released samples, then four pressed samples.
- R4: `release_o` fires when the history equals 0x000F: twelve pressed samples, then four released samples.
- R5: When `tick_i` is sampled high at rising edge k and that sample completes a pattern, the event output is high from edge k+1 to edge k+2, a single clock. `press_o` and `release_o` are never high together.
- R6: The sample taken at strobe edge k is the level `key_n_i` had at edge k-2. A change made after edge k-2 is taken at the next strobe.
- R7: A bounce inside the settling run gives no event, and so does a second run of pressed samples that follows an earlier press without twelve released samples in between.
- R8: Holding the key in one state for any number of strobes gives at most one event for that state.
- R9: Starting from reset, four pressed samples give a press event, because the history holds released samples from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sampling strobe, one clock wide |
| key_n_i | input | 1 | Raw switch line, low when pressed |
| press_o | output | 1 | One-clock pulse on a confirmed press |
| release_o | output | 1 | One-clock pulse on a confirmed release |

## Verification
The hardest case to reach is a history that comes close to a pattern but misses it. Examples are a run of four pressed samples with a released sample buried among the older twelve, or a second settle that follows a press too soon. The stimulus reaches these by walking the line through exact per-strobe sample scripts: stable-then-bounce-back, short releases and long alternations.

The synchronizer boundary is reached by changing the line exactly one clock too late for a strobe. The expected value then comes from the previous level. Glitches placed between strobes confirm that only strobe-aligned levels matter.

// File: rtl/hmd_pkg.sv
package hmd_pkg;

  localparam int MAX_HIST = 64;

  // Word with the n lowest bits set, used to build the match patterns.
  function automatic logic [MAX_HIST-1:0] low_ones(input int n);
    logic [MAX_HIST-1:0] r;
    for (int i = 0; i < MAX_HIST; i++) begin
      r[i] = (i < n);
    end
    return r;
  endfunction

endpackage

// File: rtl/hmd_sync.sv
module hmd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hmd_history.sv
module hmd_history #(
  parameter int   HIST_W  = 16,
  parameter logic RST_VAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sample,
  output logic [HIST_W-1:0] hist,
  output logic              fresh
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= {HIST_W{RST_VAL}};
      fresh <= 1'b0;
    end else begin
      fresh <= tick;
      if (tick) hist <= {hist[HIST_W-2:0], sample};
    end
  end

endmodule

// File: rtl/hmd_match.sv
module hmd_match #(
  parameter int              HIST_W      = 16,
  parameter logic [HIST_W-1:0] PRESS_PAT   = '0,
  parameter logic [HIST_W-1:0] RELEASE_PAT = '1,
  parameter bit              EN_RELEASE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] hist,
  input  logic              fresh,
  output logic              press_evt,
  output logic              release_evt
);

  always_ff @(posedge clk) begin
    if (rst) press_evt <= 1'b0;
    else     press_evt <= fresh && (hist == PRESS_PAT);
  end

  generate
    if (EN_RELEASE) begin : g_rel
      always_ff @(posedge clk) begin
        if (rst) release_evt <= 1'b0;
        else     release_evt <= fresh && (hist == RELEASE_PAT);
      end
    end else begin : g_norel
      assign release_evt = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hist_match_debounce.sv
module hist_match_debounce #(
  parameter int HIST_W      = 16,
  parameter int SETTLE_N    = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit EN_RELEASE  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic key_n_i,
  output logic press_o,
  output logic release_o
);

  localparam logic [HIST_W-1:0] SETTLE_MASK = HIST_W'(hmd_pkg::low_ones(SETTLE_N));
  localparam logic [HIST_W-1:0] PRESS_PAT   = ~SETTLE_MASK;
  localparam logic [HIST_W-1:0] RELEASE_PAT = SETTLE_MASK;

  logic              key_sync;
  logic [HIST_W-1:0] hist_q;
  logic              fresh_q;

  hmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (key_n_i),
    .q   (key_sync)
  );

  hmd_history #(.HIST_W(HIST_W), .RST_VAL(1'b1)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_i),
    .sample (key_sync),
    .hist   (hist_q),
    .fresh  (fresh_q)
  );

  hmd_match #(
    .HIST_W      (HIST_W),
    .PRESS_PAT   (PRESS_PAT),
    .RELEASE_PAT (RELEASE_PAT),
    .EN_RELEASE  (EN_RELEASE)
  ) u_match (
    .clk         (clk),
    .rst         (rst),
    .hist        (hist_q),
    .fresh       (fresh_q),
    .press_evt   (press_o),
    .release_evt (release_o)
  );

endmodule

// File: rtl/hmd_chk.sv
module hmd_chk #(
  parameter int                HIST_W      = 16,
  parameter logic [HIST_W-1:0] PRESS_PAT   = '0,
  parameter logic [HIST_W-1:0] RELEASE_PAT = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              press,
  input logic              rel,
  input logic [HIST_W-1:0] hist
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!press && !rel));

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(hist));

  // R3
  press_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    press |-> ($past(hist) == PRESS_PAT));

  // R4
  release_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    rel |-> ($past(hist) == RELEASE_PAT));

  // R5
  press_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  // R5
  release_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    rel |=> !rel);

  // R5
  event_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(press && rel));

  // R5
  event_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (press || rel) |-> $past(tick, 2));

endmodule

bind hist_match_debounce hmd_chk #(
  .HIST_W      (HIST_W),
  .PRESS_PAT   (PRESS_PAT),
  .RELEASE_PAT (RELEASE_PAT)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick_i),
  .press (press_o),
  .rel   (release_o),
  .hist  (hist_q)
);

// File: tb/sim_hist_match_debounce.sv
module sim_hist_match_debounce;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic key_n_i = 1'b1;
  logic press_o, release_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] hist_m = 16'hFFFF;
  int exp_q[$];          // 0 = press, 1 = release
  int age = 0;

  always #2 clk = ~clk;

  hist_match_debounce u0 (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .key_n_i   (key_n_i),
    .press_o   (press_o),
    .release_o (release_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of R3/R4: shift a sample in, push the expected event.
  task automatic model_shift(input logic v);
    hist_m = {hist_m[14:0], v};
    if (hist_m == 16'hFFF0) exp_q.push_back(0);
    if (hist_m == 16'h000F) exp_q.push_back(1);
  endtask

  // Line set well before the strobe; the event must arrive within the window.
  task automatic sample_tick(input logic v);
    @(negedge clk) key_n_i = v;
    repeat (3) @(negedge clk);
    tick_i = 1'b1;
    model_shift(v);
    @(negedge clk) tick_i = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 event within window", exp_q.size(), 0);
  endtask

  // R6: change arrives one clock too late, so the old level is sampled.
  task automatic late_tick(input logic v);
    logic old;
    old = key_n_i;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk) key_n_i = v;
    @(negedge clk) tick_i = 1'b1;
    model_shift(old);
    @(negedge clk) tick_i = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 late change", exp_q.size(), 0);
  endtask

  // R2: a short excursion between strobes.
  task automatic glitch();
    logic old;
    old = key_n_i;
    @(negedge clk) key_n_i = ~old;
    repeat (2) @(negedge clk);
    key_n_i = old;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic v, input int n);
    for (int i = 0; i < n; i++) sample_tick(v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (tick_i) age <= 0;
    else        age <= age + 1;
  end

  // Monitor: pop and compare every event as it appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (press_o && release_o) check(1'b0, "R5 both high", 1, 0);
      if (press_o || release_o) begin
        int kind;
        kind = press_o ? 0 : 1;
        if (exp_q.size() == 0) begin
          check(1'b0, kind == 0 ? "R3/R7/R8 unexpected press" : "R4/R7/R8 unexpected release", kind, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(e == kind, "R3 R4 event kind", kind, e);
          check(age == 1, "R5 event timing", age, 1);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(press_o == 1'b0 && release_o == 1'b0, "R1 during reset", press_o | release_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(press_o == 1'b0 && release_o == 1'b0, "R1 after reset", press_o | release_o, 0);

    // R9: press straight from reset, R8: hold it
    run(1'b0, 4);
    run(1'b0, 20);
    // R4 release, then hold
    run(1'b1, 4);
    run(1'b1, 20);

    // R2: glitches between strobes while released
    for (int i = 0; i < 6; i++) begin
      glitch();
      sample_tick(1'b1);
    end

    // R7: bounce inside settle run
    sample_tick(1'b0); sample_tick(1'b1); sample_tick(1'b0); sample_tick(1'b0);
    sample_tick(1'b1); run(1'b0, 4);
    run(1'b1, 16);

    // R7: stable then bounce back, second settle too soon
    run(1'b0, 4);
    sample_tick(1'b1);
    run(1'b0, 6);
    // short release from pressed
    run(1'b0, 16);
    run(1'b1, 3);
    run(1'b0, 8);
    run(1'b1, 16);

    // R6: late change then normal sampling
    late_tick(1'b0);
    run(1'b0, 4);
    late_tick(1'b1);
    run(1'b1, 16);

    // alternating pattern
    for (int i = 0; i < 32; i++) sample_tick(logic'(i % 2));
    run(1'b1, 16);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 R4 all events seen", exp_q.size(), 0);
    finish_run();
  end

endmodule